// File: doc/BRIEF.md
# Interleaved Multithreading Thread Selector

This block decides, cycle by cycle, which hardware thread context may place its next instruction into one shared pipeline. Each context reports whether it is ready to issue and can raise a one-cycle pulse when it hits a long-latency event such as a page fault or a second-level cache miss. The pipeline answers with an accept strobe when it takes the offered instruction. The selector then presents a thread index and a valid flag. Both are combinational functions of the current inputs and of two internal registers: a rotation pointer and the index shown in the previous cycle.

A mode input picks between two interleaving policies. In the fine policy the pointer moves past the thread that issued each time an instruction is accepted, so contexts take turns and stalled ones are passed over. In the coarse policy the pointer names an owning thread that keeps the pipeline through short stalls. Ownership passes to another ready thread only when the owner signals a long-latency event. Both policies share the one pointer, so changing mode keeps the rotation position.

Top module: `thread_issue_selector`

## Requirements
- R1: After synchronous reset the rotation pointer is 0 and the held index is 0. With no thread ready, `sel_tid` reads 0 and `issue_vld` is low. With all threads ready in either mode, thread 0 is offered first.
- R2: With `mode_coarse`=0, `sel_tid` is the lowest-numbered ready thread at or after the pointer, searching upward and wrapping past the last thread to thread 0. `issue_vld` is high whenever any thread is ready.
- R3: With `mode_coarse`=0, a cycle with `issue_ack` and `issue_vld` both high sets the pointer to one past the offered thread, wrapping to 0, for the next cycle. A cycle without `issue_ack` leaves the pointer unchanged.
- R4: `issue_vld` is never high while `thr_ready` is low for the offered thread, so stalled threads are skipped.
- R5: With `mode_coarse`=0 and no thread ready, `issue_vld` is low and `sel_tid` keeps the value it showed in the previous cycle.
- R6: With `mode_coarse`=1, `sel_tid` is the owning thread (the pointer), and `issue_vld` equals that thread's ready bit. A short stall of the owner drops `issue_vld` without moving ownership.
- R7: With `mode_coarse`=1, `issue_ack` does not move the pointer.
- R8: With `mode_coarse`=1, a `thr_lle` pulse from the owner moves ownership in the next cycle to the first ready thread after the owner in wrapping upward order. The owner itself is not a candidate.
- R9: With `mode_coarse`=1, an owner event while no other thread is ready leaves ownership unchanged.
- R10: `thr_lle` pulses from threads other than the owner, and all `thr_lle` pulses while `mode_coarse`=0, have no effect on the pointer.
- R11: Changing `mode_coarse` keeps the pointer. The fine search continues from the coarse owner, and the coarse owner is the last fine pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_coarse | input | 1 | 0 = switch threads per instruction, 1 = switch on long-latency event |
| thr_ready | input | NUM_THREADS | Per-thread ready flag (1 = can issue) |
| thr_lle | input | NUM_THREADS | Per-thread long-latency event pulse |
| issue_ack | input | 1 | Pipeline accepted the offered instruction this cycle |
| sel_tid | output | TID_W | Index of the offered thread |
| issue_vld | output | 1 | Offered thread has an instruction ready to issue |

## Verification
`sel_tid` and `issue_vld` respond in the same cycle to changes in `thr_ready` and `mode_coarse`. The bench therefore drives inputs on the falling edge and compares a short settle delay later, before the next rising edge. The effects of `issue_ack` and `thr_lle` pass through the pointer register and appear exactly one cycle later. The bench's reference model updates its own pointer and held index at each rising edge, so every comparison in the following cycle already reflects them. A fixed-seed random phase runs mixed modes after the directed corner cases, using a thread count of three so that the wrap is not a power of two.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    typedef enum logic {
        TSEL_FINE   = 1'b0,
        TSEL_COARSE = 1'b1
    } tsel_mode_e;

    // width of a thread index for n contexts (at least one bit)
    function automatic int tid_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // a + b reduced modulo n, for a, b < n
    function automatic int wrap_add(input int a, input int b, input int n);
        int s;
        s = a + b;
        return (s >= n) ? s - n : s;
    endfunction

endpackage

// File: rtl/tsel_rr_search.sv
module tsel_rr_search
    import tsel_pkg::*;
#(
    parameter int NT = 2,
    parameter int TW = tid_width(NT)
) (
    input  logic [NT-1:0] mask,
    input  logic [TW-1:0] start,
    output logic          found,
    output logic [TW-1:0] idx
);

    int pos;

    always_comb begin
        found = 1'b0;
        idx   = start;
        pos   = 0;
        for (int k = 0; k < NT; k++) begin
            pos = wrap_add(int'(start), k, NT);
            if (!found && mask[pos]) begin
                found = 1'b1;
                idx   = TW'(pos);
            end
        end
    end

endmodule

// File: rtl/tsel_policy.sv
module tsel_policy
    import tsel_pkg::*;
#(
    parameter int NT = 2,
    parameter int TW = tid_width(NT)
) (
    input  tsel_mode_e    mode,
    input  logic [NT-1:0] ready,
    input  logic [NT-1:0] lle,
    input  logic          ack,
    input  logic [TW-1:0] ptr,
    input  logic [TW-1:0] last_sel,
    output logic [TW-1:0] sel,
    output logic          vld,
    output logic [TW-1:0] ptr_nxt
);

    localparam logic [TW-1:0] LAST_TID = TW'(NT - 1);

    logic          rr_found;
    logic [TW-1:0] rr_idx;
    logic          alt_found;
    logic [TW-1:0] alt_idx;
    logic [TW-1:0] ptr_inc;
    logic [TW-1:0] rr_inc;
    logic [NT-1:0] alt_mask;

    assign ptr_inc  = (ptr == LAST_TID) ? '0 : ptr + 1'b1;
    assign rr_inc   = (rr_idx == LAST_TID) ? '0 : rr_idx + 1'b1;
    assign alt_mask = ready & ~(NT'(1) << ptr);

    // fine policy: first ready thread from the pointer on
    tsel_rr_search #(.NT(NT), .TW(TW)) u_fine_search (
        .mask  (ready),
        .start (ptr),
        .found (rr_found),
        .idx   (rr_idx)
    );

    // coarse policy: successor of the owner among the other ready threads
    tsel_rr_search #(.NT(NT), .TW(TW)) u_alt_search (
        .mask  (alt_mask),
        .start (ptr_inc),
        .found (alt_found),
        .idx   (alt_idx)
    );

    always_comb begin
        if (mode == TSEL_COARSE) begin
            sel     = ptr;
            vld     = ready[ptr];
            ptr_nxt = (lle[ptr] && alt_found) ? alt_idx : ptr;
        end else begin
            sel     = rr_found ? rr_idx : last_sel;
            vld     = rr_found;
            ptr_nxt = (ack && rr_found) ? rr_inc : ptr;
        end
    end

endmodule

// File: rtl/tsel_state.sv
module tsel_state
    import tsel_pkg::*;
#(
    parameter int NT = 2,
    parameter int TW = tid_width(NT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] ptr_nxt,
    input  logic [TW-1:0] sel_now,
    output logic [TW-1:0] ptr,
    output logic [TW-1:0] last_sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            last_sel <= '0;
        end else begin
            ptr      <= ptr_nxt;
            last_sel <= sel_now;
        end
    end

endmodule

// File: rtl/thread_issue_selector.sv
module thread_issue_selector
    import tsel_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int TID_W       = tid_width(NUM_THREADS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode_coarse,
    input  logic [NUM_THREADS-1:0] thr_ready,
    input  logic [NUM_THREADS-1:0] thr_lle,
    input  logic                   issue_ack,
    output logic [TID_W-1:0]       sel_tid,
    output logic                   issue_vld
);

    tsel_mode_e       mode;
    logic [TID_W-1:0] ptr;
    logic [TID_W-1:0] last_sel;
    logic [TID_W-1:0] ptr_nxt;

    assign mode = tsel_mode_e'(mode_coarse);

    tsel_policy #(.NT(NUM_THREADS), .TW(TID_W)) u_policy (
        .mode     (mode),
        .ready    (thr_ready),
        .lle      (thr_lle),
        .ack      (issue_ack),
        .ptr      (ptr),
        .last_sel (last_sel),
        .sel      (sel_tid),
        .vld      (issue_vld),
        .ptr_nxt  (ptr_nxt)
    );

    tsel_state #(.NT(NUM_THREADS), .TW(TID_W)) u_state (
        .clk      (clk),
        .rst      (rst),
        .ptr_nxt  (ptr_nxt),
        .sel_now  (sel_tid),
        .ptr      (ptr),
        .last_sel (last_sel)
    );

endmodule

// File: rtl/thread_issue_selector_chk.sv
module thread_issue_selector_chk #(
    parameter int NUM_THREADS = 2,
    parameter int TID_W       = 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   mode_coarse,
    input logic [NUM_THREADS-1:0] thr_ready,
    input logic [NUM_THREADS-1:0] thr_lle,
    input logic                   issue_ack,
    input logic [TID_W-1:0]       sel_tid,
    input logic                   issue_vld
);

    // R4: a stalled thread is never offered as valid
    a_r4_vld_needs_ready: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> thr_ready[sel_tid]);

    // R2, R5: valid tracks presence of any ready thread in fine mode
    a_r2_fine_vld_any: assert property (@(posedge clk) disable iff (rst)
        !mode_coarse |-> (issue_vld == ($countones(thr_ready) != 0)));

    // R5: fine mode with nothing ready holds the shown index
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mode_coarse || (|thr_ready) || $stable(sel_tid)));

    // R6, R7, R10: coarse owner stays put without an owner event
    a_r6_coarse_stay: assert property (@(posedge clk) disable iff (rst)
        (mode_coarse && !thr_lle[sel_tid]) |=> (!mode_coarse || $stable(sel_tid)));

    // R8: owner event with another ready thread moves ownership
    a_r8_coarse_switch: assert property (@(posedge clk) disable iff (rst)
        (mode_coarse && thr_lle[sel_tid] &&
         ((thr_ready & ~(NUM_THREADS'(1) << sel_tid)) != '0))
        |=> (!mode_coarse || (sel_tid != $past(sel_tid))));

    // R3: an accepted fine issue rotates away when another thread is ready
    a_r3_fine_rotate: assert property (@(posedge clk) disable iff (rst)
        (!mode_coarse && issue_vld && issue_ack)
        |=> (mode_coarse ||
             ((thr_ready & ~(NUM_THREADS'(1) << $past(sel_tid))) == '0) ||
             (sel_tid != $past(sel_tid))));

endmodule

bind thread_issue_selector thread_issue_selector_chk #(
    .NUM_THREADS (NUM_THREADS),
    .TID_W       (TID_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_coarse (mode_coarse),
    .thr_ready   (thr_ready),
    .thr_lle     (thr_lle),
    .issue_ack   (issue_ack),
    .sel_tid     (sel_tid),
    .issue_vld   (issue_vld)
);

// File: tb/thread_issue_selector_test.sv
module thread_issue_selector_test;

    localparam int NT = 3;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_coarse = 1'b0;
    logic [NT-1:0] thr_ready = '0;
    logic [NT-1:0] thr_lle = '0;
    logic          issue_ack = 1'b0;
    logic [TW-1:0] sel_tid;
    logic          issue_vld;

    int n_checks = 0;
    int n_errs   = 0;
    int m_ptr    = 0;
    int m_last   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    thread_issue_selector #(.NUM_THREADS(NT), .TID_W(TW)) uut (
        .clk         (clk),
        .rst         (rst),
        .mode_coarse (mode_coarse),
        .thr_ready   (thr_ready),
        .thr_lle     (thr_lle),
        .issue_ack   (issue_ack),
        .sel_tid     (sel_tid),
        .issue_vld   (issue_vld)
    );

    function automatic int rr_find(input logic [NT-1:0] m, input int s);
        for (int k = 0; k < NT; k++) begin
            if (m[(s + k) % NT]) return (s + k) % NT;
        end
        return -1;
    endfunction

    task automatic step(input logic md, input logic [NT-1:0] rdy,
                        input logic [NT-1:0] ev, input logic ack,
                        input logic do_rst, input string tag);
        int  e_sel;
        bit  e_vld;
        int  p;
        @(negedge clk);
        mode_coarse = md;
        thr_ready   = rdy;
        thr_lle     = ev;
        issue_ack   = ack;
        rst         = do_rst;
        #1;
        if (md) begin
            e_sel = m_ptr;
            e_vld = rdy[m_ptr];
        end else begin
            p     = rr_find(rdy, m_ptr);
            e_vld = (p >= 0);
            e_sel = e_vld ? p : m_last;
        end
        if (!do_rst) begin
            n_checks++;
            if (int'(sel_tid) != e_sel || issue_vld != e_vld) begin
                n_errs++;
                $display("FAIL %s: sel_tid=%0d issue_vld=%0b expected sel_tid=%0d issue_vld=%0b",
                         tag, sel_tid, issue_vld, e_sel, e_vld);
            end
        end
        @(posedge clk);
        if (do_rst) begin
            m_ptr  = 0;
            m_last = 0;
        end else begin
            m_last = e_sel;
            if (!md && ack && e_vld) m_ptr = (e_sel + 1) % NT;
            if (md && ev[m_ptr]) begin
                p = rr_find(rdy & ~(NT'(1) << m_ptr), (m_ptr + 1) % NT);
                if (p >= 0) m_ptr = p;
            end
        end
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        string tg;
        void'($urandom(32'd4711));
        step(0, '0, '0, 0, 1, "R1");
        step(0, '0, '0, 0, 1, "R1");
        // R1: reset state, nothing ready
        step(0, 3'b000, '0, 0, 0, "R1");
        // R1, R2, R3: all ready, rotate 0,1,2,0
        step(0, 3'b111, '0, 1, 0, "R1");
        step(0, 3'b111, '0, 1, 0, "R3");
        step(0, 3'b111, '0, 1, 0, "R3");
        step(0, 3'b111, '0, 1, 0, "R3");
        // R3: no ack keeps pointer
        step(0, 3'b111, '0, 0, 0, "R3");
        step(0, 3'b111, '0, 0, 0, "R3");
        // R4: thread 1 stalled is skipped, wrap past 2
        step(0, 3'b101, '0, 1, 0, "R4");
        step(0, 3'b101, '0, 1, 0, "R4");
        step(0, 3'b101, '0, 1, 0, "R4");
        // R5: nothing ready holds last index
        step(0, 3'b000, '0, 1, 0, "R5");
        step(0, 3'b000, '0, 0, 0, "R5");
        // R10: events in fine mode ignored
        step(0, 3'b010, 3'b111, 0, 0, "R10");
        step(0, 3'b111, 3'b111, 0, 0, "R10");
        // R11: enter coarse, owner is current pointer
        step(1, 3'b111, '0, 1, 0, "R11");
        // R7: ack does not move owner
        step(1, 3'b111, '0, 1, 0, "R7");
        // R6: short stall waits on owner
        step(1, 3'b000, '0, 1, 0, "R6");
        step(1, 3'b110, '0, 0, 0, "R6");
        // R10: event from non-owner ignored
        step(1, 3'b111, 3'b110, 0, 0, "R10");
        step(1, 3'b111, 3'b110, 0, 0, "R10");
        // R8: owner event moves to next ready after it
        step(1, 3'b011, 3'b001, 0, 0, "R8");
        step(1, 3'b011, 3'b000, 0, 0, "R8");
        step(1, 3'b101, 3'b010, 0, 0, "R8");
        step(1, 3'b101, 3'b000, 0, 0, "R8");
        // R9: owner event with nobody else ready
        step(1, 3'b100, 3'b100, 0, 0, "R9");
        step(1, 3'b000, 3'b100, 0, 0, "R9");
        step(1, 3'b000, 3'b000, 0, 0, "R9");
        // R11: back to fine, search from owner
        step(0, 3'b111, '0, 1, 0, "R11");
        step(0, 3'b111, '0, 1, 0, "R11");
        // R1: reset mid-run then all ready in coarse mode
        step(1, 3'b111, '0, 0, 1, "R1");
        step(1, 3'b111, '0, 0, 0, "R1");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic md;
            logic [NT-1:0] rd;
            logic [NT-1:0] ev;
            md = (i / 97) % 2 == 1;
            if (($urandom % 50) == 0) md = ~md;
            rd = NT'($urandom);
            ev = ((($urandom % 4) == 0) ? NT'($urandom) : '0);
            if (md) tg = ev != '0 ? "R8" : "R6";
            else    tg = rd == '0 ? "R5" : "R2";
            step(md, rd, ev, 1'($urandom), 0, tg);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule